// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Controller

This block moves a programmed run of bytes between one I/O device and memory while the processor has let go of the bus. Software loads a start address for each side, a byte count and a control word. The control word selects the direction and one of three pacing modes, and a start bit in the same word launches the run. The controller then waits for the device to raise its request. It asks the processor for the bus, and once the processor grants it, the controller acknowledges the device and performs the byte cycles. When the count runs out it raises an interrupt.

Data never passes through the controller. In each byte cycle it drives the memory address and fires a memory strobe and an I/O strobe together, so the device and the memory exchange the byte directly. The three modes differ only in when the bus goes back to the processor:
- Demand mode keeps the bus while the device keeps requesting.
- Single mode returns the bus after every byte.
- Block mode keeps the bus until the whole count is done.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: Register writes use `cfg_sel`, with these select codes: 0 is the source address, 1 is the destination address, 2 is the count, 3 is control and 4 is the interrupt clear. Control bit 0 sets the direction: 0 moves memory to the device, 1 moves the device to memory. Control bits 2:1 set the mode: 00 demand, 01 single, 10 block, 11 block. Setting control bit 3 starts a transfer, and `busy` is high from the cycle after the start write until completion. After reset, `busy`, `irq`, `hold_req`, `dack`, `bus_oe` and all strobes are low.
- R2: `hold_req` rises only after `dreq` has been seen high. `dack` is high only while `hold_ack` is high.
- R3: `bus_oe`, a nonzero `addr` and any strobe appear only after `hold_ack` has been sampled high. They all drop in the same cycle that `hold_req` drops.
- R4: When control bit 0 is 0, each byte pulses `mem_rd` and `io_wr` together, and `mem_wr` and `io_rd` stay low. The address starts at the source register.
- R5: When control bit 0 is 1, each byte pulses `io_rd` and `mem_wr` together, and `mem_rd` and `io_wr` stay low. The address starts at the destination register.
- R6: Each byte takes three cycles: address setup, strobes, then recovery. The address advances by one per byte, so back-to-back strobes are exactly three cycles apart.
- R7: A count value of N moves N+1 bytes. The transfer ends when the count wraps past zero, in every mode.
- R8: In demand mode, a byte finishing while `dreq` is low releases the bus and pauses. A later `dreq` resumes the transfer at the next address.
- R9: In single mode, `hold_req` drops after every byte. It is requested again while `dreq` is high.
- R10: In block mode, `hold_req` stays high from grant to the last byte, even if `dreq` drops.
- R11: `irq` rises when the last byte completes. It stays high until a write with select 4 and bit 0 set clears it.
- R12: While `busy` is high, writes to the address, count and control registers are ignored, including a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, sticky |
| dreq | input | 1 | Device request |
| dack | output | 1 | Device acknowledge |
| hold_req | output | 1 | Bus request to processor |
| hold_ack | input | 1 | Bus grant from processor |
| bus_oe | output | 1 | Controller owns address and strobes |
| addr | output | AW | Memory address, zero when not driving |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |

## Verification
Several kinds of wrong internal state show up at the ports in different ways:
- A corrupted address pointer appears at the very next strobe as an address that is not the start address plus the byte index.
- A wrong count shows up only at the end, as a byte total that differs from N+1 or as an interrupt that never arrives.
- A sequencer that slips a state shows within one byte, either as a strobe spacing other than three cycles in the held-bus modes or as a strobe or address appearing without a grant.

Mode mistakes appear as the wrong number of bus-request rises per transfer.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        XM_DEMAND = 2'd0,
        XM_SINGLE = 2'd1,
        XM_BLOCK  = 2'd2
    } xmode_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_ARMED   = 3'd1,
        S_HREQ    = 3'd2,
        S_SETUP   = 3'd3,
        S_STROBE  = 3'd4,
        S_RECOVER = 3'd5
    } seq_e;

    typedef struct packed {
        logic   to_mem;   // 1: device -> memory
        xmode_e mode;
    } xcfg_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strb_t;

    localparam logic [2:0] SEL_SRC = 3'd0;
    localparam logic [2:0] SEL_DST = 3'd1;
    localparam logic [2:0] SEL_CNT = 3'd2;
    localparam logic [2:0] SEL_CTL = 3'd3;
    localparam logic [2:0] SEL_CLR = 3'd4;

    localparam int CTL_DIR_BIT   = 0;
    localparam int CTL_MODE_LO   = 1;
    localparam int CTL_START_BIT = 3;

    function automatic xmode_e decode_mode(input logic [1:0] f);
        case (f)
            2'd0:    return XM_DEMAND;
            2'd1:    return XM_SINGLE;
            default: return XM_BLOCK;
        endcase
    endfunction

    function automatic strb_t strobes_for(input logic to_mem);
        strb_t s;
        s.mem_rd = !to_mem;
        s.io_wr  = !to_mem;
        s.io_rd  = to_mem;
        s.mem_wr = to_mem;
        return s;
    endfunction

endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
    import dmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          busy,
    output logic [AW-1:0] cnt_q,
    output logic [AW-1:0] launch_addr,
    output xcfg_t         cfg_q,
    output logic          start,
    output logic          irq_clr
);
    logic [AW-1:0] src_q, dst_q;
    logic          open_w;

    assign open_w  = cfg_we && !busy;
    assign start   = open_w && (cfg_sel == SEL_CTL) && cfg_wdata[CTL_START_BIT];
    assign irq_clr = cfg_we && (cfg_sel == SEL_CLR) && cfg_wdata[0];
    // pointer base follows the direction being written with the start bit
    assign launch_addr = cfg_wdata[CTL_DIR_BIT] ? dst_q : src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            cfg_q <= '{to_mem: 1'b0, mode: XM_DEMAND};
        end else if (open_w) begin
            case (cfg_sel)
                SEL_SRC: src_q <= cfg_wdata;
                SEL_DST: dst_q <= cfg_wdata;
                SEL_CNT: cnt_q <= cfg_wdata;
                SEL_CTL: begin
                    cfg_q.to_mem <= cfg_wdata[CTL_DIR_BIT];
                    cfg_q.mode   <= decode_mode(cfg_wdata[CTL_MODE_LO +: 2]);
                end
                default: ;
            endcase
        end
    end

    // R12
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_we) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(cfg_q)));

endmodule

// File: rtl/dmx_walk.sv
module dmx_walk #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] count,
    output logic [AW-1:0] ptr,
    output logic          last
);
    logic [AW-1:0] left;

    assign last = (left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            left <= '0;
        end else if (load) begin
            ptr  <= base;
            left <= count;
        end else if (step) begin
            ptr  <= ptr + 1'b1;
            left <= left - 1'b1;
        end
    end

    // R6
    walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> ($stable(ptr) && $stable(left)));

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   dreq,
    input  logic   hold_ack,
    input  xcfg_t  cfg,
    input  logic   last,
    input  logic   irq_clr,
    output logic   busy,
    output logic   hold_req,
    output logic   dack,
    output logic   bus_oe,
    output strb_t  strb,
    output logic   load,
    output logic   step,
    output logic   irq
);
    seq_e state, nxt;
    logic done_w;

    assign busy     = (state != S_IDLE);
    assign bus_oe   = (state == S_SETUP) || (state == S_STROBE) || (state == S_RECOVER);
    assign hold_req = bus_oe || (state == S_HREQ);
    assign dack     = bus_oe;
    assign strb     = (state == S_STROBE) ? strobes_for(cfg.to_mem) : '0;
    assign load     = start && (state == S_IDLE);
    assign step     = (state == S_RECOVER);
    assign done_w   = step && last;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:    if (start)    nxt = S_ARMED;
            S_ARMED:   if (dreq)     nxt = S_HREQ;
            S_HREQ:    if (hold_ack) nxt = S_SETUP;
            S_SETUP:                 nxt = S_STROBE;
            S_STROBE:                nxt = S_RECOVER;
            S_RECOVER: begin
                if (last) nxt = S_IDLE;
                else begin
                    case (cfg.mode)
                        XM_BLOCK:  nxt = S_SETUP;
                        XM_DEMAND: nxt = dreq ? S_SETUP : S_ARMED;
                        default:   nxt = S_ARMED;
                    endcase
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            irq   <= 1'b0;
        end else begin
            state <= nxt;
            if (done_w)       irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

    // R3
    grant_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(hold_ack));
    // R3
    release_together_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_req) |-> $fell(bus_oe));
    // R2
    req_after_dreq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_req) |-> $past(dreq));
    // R4
    strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(strb) == 0) || ($countones(strb) == 2));
    // R11
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr && !done_w) |=> irq);
    // R10
    block_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == XM_BLOCK && bus_oe && !done_w) |=> hold_req);

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dmx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          busy,
    output logic          irq,
    input  logic          dreq,
    output logic          dack,
    output logic          hold_req,
    input  logic          hold_ack,
    output logic          bus_oe,
    output logic [AW-1:0] addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          io_rd,
    output logic          io_wr
);
    logic [AW-1:0] cnt_q, launch_addr, ptr;
    xcfg_t         cfg_q;
    strb_t         strb;
    logic          start, irq_clr, load, step, last;

    dmx_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .cnt_q(cnt_q),
        .launch_addr(launch_addr), .cfg_q(cfg_q), .start(start),
        .irq_clr(irq_clr)
    );

    dmx_walk #(.AW(AW)) u_walk (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .base(launch_addr), .count(cnt_q), .ptr(ptr), .last(last)
    );

    dmx_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .dreq(dreq),
        .hold_ack(hold_ack), .cfg(cfg_q), .last(last), .irq_clr(irq_clr),
        .busy(busy), .hold_req(hold_req), .dack(dack), .bus_oe(bus_oe),
        .strb(strb), .load(load), .step(step), .irq(irq)
    );

    assign addr   = bus_oe ? ptr : '0;
    assign mem_rd = strb.mem_rd;
    assign mem_wr = strb.mem_wr;
    assign io_rd  = strb.io_rd;
    assign io_wr  = strb.io_wr;

endmodule

// File: tb/sim_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_dma_xfer_ctrl;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic dreq = 1'b0;
    logic hold_ack = 1'b0;
    logic busy, irq, dack, hold_req, bus_oe, mem_rd, mem_wr, io_rd, io_wr;
    logic [AW-1:0] addr;

    always #2.5 clk = ~clk;

    dma_xfer_ctrl #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .irq(irq), .dreq(dreq),
        .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack),
        .bus_oe(bus_oe), .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr)
    );

    // processor model: grants one cycle after request
    always @(posedge clk) hold_ack <= rst ? 1'b0 : hold_req;

    int total = 0, bad = 0, cyc = 0;
    int n_xfer = 0, addr_bad = 0, strb_bad = 0, oe_bad = 0, hr_rises = 0, gap_bad = 0;
    int last_cyc = 0, exp_gap = 0;
    logic [AW-1:0] exp_base = '0;
    logic exp_dir = 1'b0;
    logic hr_prev = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (mem_rd || mem_wr || io_rd || io_wr) begin
                if ({mem_rd, io_wr, io_rd, mem_wr} != (exp_dir ? 4'b0011 : 4'b1100))
                    strb_bad = strb_bad + 1;
                if (addr != exp_base + AW'(n_xfer)) addr_bad = addr_bad + 1;
                if (exp_gap != 0 && n_xfer > 0 && (cyc - last_cyc) != exp_gap)
                    gap_bad = gap_bad + 1;
                last_cyc = cyc;
                n_xfer = n_xfer + 1;
            end
            if ((bus_oe && !(hold_ack && hold_req)) || (dack && !hold_ack) ||
                (!bus_oe && (addr != '0 || mem_rd || mem_wr || io_rd || io_wr)) ||
                (bus_oe != hold_req && !hold_req))
                oe_bad = oe_bad + 1;
            if (hold_req && !hr_prev) hr_rises = hr_rises + 1;
            hr_prev = hold_req;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic mon_clear(input logic [AW-1:0] base, input logic dir, input int gap);
        n_xfer = 0; addr_bad = 0; strb_bad = 0; hr_rises = 0; gap_bad = 0;
        exp_base = base; exp_dir = dir; exp_gap = gap;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
    endtask

    task automatic run_one(input logic dir, input int mode, input int cnt,
                           input logic [AW-1:0] src, input logic [AW-1:0] dst);
        bit seen;
        string mtag;
        mtag = (mode == 0) ? "R8" : (mode == 1) ? "R9" : "R10";
        mon_clear(dir ? dst : src, dir, (mode == 1) ? 0 : 3);
        wr(3'd0, src);
        wr(3'd1, dst);
        wr(3'd2, AW'(cnt));
        wr(3'd3, AW'({1'b1, 2'(mode), dir}));
        dreq = 1'b1;
        wait_irq(seen);
        dreq = 1'b0;
        chk(seen, "R11 irq raised", int'(seen), 1);
        chk(n_xfer == cnt + 1, "R7 byte total", n_xfer, cnt + 1);
        chk(addr_bad == 0, dir ? "R5 address sequence" : "R4 address sequence", addr_bad, 0);
        chk(strb_bad == 0, dir ? "R5 strobe pair" : "R4 strobe pair", strb_bad, 0);
        chk(gap_bad == 0, "R6 three-cycle spacing", gap_bad, 0);
        chk(hr_rises == ((mode == 1) ? cnt + 1 : 1), mtag, hr_rises, (mode == 1) ? cnt + 1 : 1);
        chk(!busy && !hold_req, "R1 idle after done", int'(busy), 0);
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R11 irq sticky", int'(irq), 1);
        wr(3'd4, 16'h0001);
        chk(irq == 1'b0, "R11 irq cleared", int'(irq), 0);
    endtask

    initial begin
        bit seen;
        repeat (4) @(negedge clk);
        chk(!busy && !irq && !hold_req && !dack && !bus_oe && !mem_rd && !mem_wr && !io_rd && !io_wr,
            "R1 reset state", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);

        // sweep direction x mode x count
        for (int d = 0; d < 2; d++)
            for (int m = 0; m < 3; m++)
                for (int c = 0; c < 4; c++)
                    run_one(d[0], m, (c == 3) ? 5 : c, AW'(16'h0100 + 16 * c), AW'(16'h8000 + 32 * m));

        // R2 / R12: armed without request, then rewrite while busy
        mon_clear(16'h0200, 1'b0, 3);
        wr(3'd0, 16'h0200);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'h0008);
        repeat (10) @(negedge clk);
        chk(busy && !hold_req && !dack, "R2 no request without dreq", int'(hold_req), 0);
        wr(3'd0, 16'h0900);
        wr(3'd2, 16'd9);
        wr(3'd3, 16'h000D);
        dreq = 1'b1;
        wait_irq(seen);
        dreq = 1'b0;
        chk(n_xfer == 4, "R12 count kept", n_xfer, 4);
        chk(addr_bad == 0 && strb_bad == 0, "R12 address and direction kept", addr_bad + strb_bad, 0);
        wr(3'd4, 16'h0001);

        // R8: demand pause and resume
        mon_clear(16'h0300, 1'b1, 0);
        wr(3'd1, 16'h0300);
        wr(3'd2, 16'd5);
        wr(3'd3, 16'h0009);
        dreq = 1'b1;
        for (int i = 0; i < 200 && n_xfer < 2; i++) @(negedge clk);
        dreq = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_xfer == 2, "R8 paused byte total", n_xfer, 2);
        chk(!hold_req && busy, "R8 bus released while paused", int'(hold_req), 0);
        dreq = 1'b1;
        wait_irq(seen);
        dreq = 1'b0;
        chk(n_xfer == 6 && addr_bad == 0, "R8 resumed total", n_xfer, 6);
        chk(hr_rises == 2, "R8 request count", hr_rises, 2);
        wr(3'd4, 16'h0001);

        // R10: block runs to the end after a short request pulse
        mon_clear(16'h0400, 1'b0, 3);
        wr(3'd0, 16'h0400);
        wr(3'd2, 16'd7);
        wr(3'd3, 16'h000C);
        dreq = 1'b1;
        for (int i = 0; i < 50 && !hold_req; i++) @(negedge clk);
        dreq = 1'b0;
        wait_irq(seen);
        chk(n_xfer == 8 && hr_rises == 1, "R10 block without dreq", n_xfer, 8);
        wr(3'd4, 16'h0001);

        chk(oe_bad == 0, "R3 bus ownership", oe_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule